// File: doc/BRIEF.md
# Lookahead ALU with Status Flags

A purely combinational arithmetic and logic unit with a parameterised operand width (16 bits by default). A 3-bit function code selects one of eight operations: three additions (one with operand A inverted, one with operand B inverted, one plain), three bitwise operations and two constant fills. A carry input feeds the additions, so the two inverted-operand forms become true subtractions when it is 1.

Carries are not rippled. Per-bit generate (AND) and propagate (OR) terms pass through a logarithmic parallel-prefix network. The network yields every internal carry, the carry-out, and group generate and propagate terms. The group terms leave the block active low, so that several units can be joined through an external lookahead stage. A zero flag and a two's-complement overflow flag complete the status outputs. For non-arithmetic functions the cascade and overflow outputs are held at fixed inactive levels.

Top module: `lkalu_core`

## Requirements
- R1: Function code 3'b000 drives every result bit to 0.
- R2: Function code 3'b111 drives every result bit to 1.
- R3: Function code 3'b001 gives (NOT A) + B + carry_in, truncated to the operand width. carry_out is the bit above the operand width of that sum.
- R4: Function code 3'b010 gives A + (NOT B) + carry_in, truncated to the operand width. carry_out is the bit above the operand width of that sum.
- R5: Function code 3'b011 gives A + B + carry_in, truncated to the operand width. carry_out is the bit above the operand width of that sum.
- R6: Function codes 3'b100, 3'b101 and 3'b110 give A XOR B, A OR B and A AND B respectively, bit by bit.
- R7: zero_flag is 1 exactly when every result bit is 0, whatever the function code.
- R8: For the three addition codes, ovf_flag is the XOR of the carry into the top bit and the carry out of it. This equals signed overflow of the two conditioned operands: both addends have the same sign bit and the sum has the other sign.
- R9: For the three addition codes, grp_gen_n is 0 exactly when the conditioned operands produce a carry-out with carry_in at 0. grp_prop_n is 0 exactly when every bit position has at least one conditioned operand bit at 1.
- R10: For the five non-addition codes, carry_out and ovf_flag are 0, and grp_gen_n and grp_prop_n are 1.
- R11: With carry_in at 1, code 3'b001 gives B minus A and code 3'b010 gives A minus B, modulo 2 to the power of the width.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| opnd_a | input | W (16) | Operand A |
| opnd_b | input | W (16) | Operand B |
| func_sel | input | 3 | Function code |
| carry_in | input | 1 | Carry into the least significant bit |
| result | output | W (16) | Function result |
| zero_flag | output | 1 | High when result is all zeros |
| ovf_flag | output | 1 | Signed overflow of addition codes |
| carry_out | output | 1 | Carry out of the most significant bit |
| grp_prop_n | output | 1 | Group propagate, active low |
| grp_gen_n | output | 1 | Group generate, active low |

## Verification
Carry-out and overflow can be raised by the same addition. So can group generate and group propagate, which can also coincide with a carry-in that passes through the whole group. A small 4-bit instance is swept over every operand pair, every function code and both carry-in values, so that every such coincidence occurs. A 16-bit instance receives directed corner cases and pseudo-random operands. Each output field is compared with a value the bench computes by wide integer addition and sign comparison of the conditioned operands.

// File: rtl/lkalu_pkg.sv
package lkalu_pkg;

  typedef enum logic [2:0] {
    FN_CLEAR  = 3'b000,
    FN_NA_B   = 3'b001,
    FN_A_NB   = 3'b010,
    FN_ADD    = 3'b011,
    FN_XOR    = 3'b100,
    FN_OR     = 3'b101,
    FN_AND    = 3'b110,
    FN_PRESET = 3'b111
  } alu_fn_e;

  function automatic logic fn_is_arith(alu_fn_e fn);
    return (fn == FN_NA_B) || (fn == FN_A_NB) || (fn == FN_ADD);
  endfunction

endpackage

// File: rtl/lkalu_opnd_cond.sv
module lkalu_opnd_cond
  import lkalu_pkg::*;
#(
  parameter int W = 16
) (
  input  logic [W-1:0] opnd_a,
  input  logic [W-1:0] opnd_b,
  input  alu_fn_e      fn,
  output logic [W-1:0] cond_x,
  output logic [W-1:0] cond_y
);

  always_comb begin
    cond_x = (fn == FN_NA_B) ? ~opnd_a : opnd_a;
    cond_y = (fn == FN_A_NB) ? ~opnd_b : opnd_b;
  end

endmodule

// File: rtl/lkalu_prefix.sv
module lkalu_prefix #(
  parameter int W = 16
) (
  input  logic [W-1:0] cond_x,
  input  logic [W-1:0] cond_y,
  input  logic         carry_in,
  output logic [W:0]   carry_vec,
  output logic         grp_gen,
  output logic         grp_prop
);

  localparam int LVL = (W > 1) ? $clog2(W) : 1;

  logic [W-1:0] pre_g;
  logic [W-1:0] pre_p;

  // Kogge-Stone prefix over (generate, propagate) pairs
  always_comb begin
    logic [W-1:0] g_cur;
    logic [W-1:0] p_cur;
    logic [W-1:0] g_nxt;
    logic [W-1:0] p_nxt;
    g_cur = cond_x & cond_y;
    p_cur = cond_x | cond_y;
    for (int l = 0; l < LVL; l++) begin
      for (int i = 0; i < W; i++) begin
        if (i >= (1 << l)) begin
          g_nxt[i] = g_cur[i] | (p_cur[i] & g_cur[i-(1<<l)]);
          p_nxt[i] = p_cur[i] & p_cur[i-(1<<l)];
        end else begin
          g_nxt[i] = g_cur[i];
          p_nxt[i] = p_cur[i];
        end
      end
      g_cur = g_nxt;
      p_cur = p_nxt;
    end
    pre_g = g_cur;
    pre_p = p_cur;
  end

  assign carry_vec[0] = carry_in;

  for (genvar i = 0; i < W; i++) begin : g_carry
    assign carry_vec[i+1] = pre_g[i] | (pre_p[i] & carry_in);
  end

  assign grp_gen  = pre_g[W-1];
  assign grp_prop = pre_p[W-1];

  // R9: a group that propagates everywhere passes carry_in to the top
  always_comb begin
    if (grp_prop) begin
      prop_carry_chk: assert (carry_vec[W] == (carry_in | grp_gen));
    end
  end

endmodule

// File: rtl/lkalu_result_mux.sv
module lkalu_result_mux
  import lkalu_pkg::*;
#(
  parameter int W = 16
) (
  input  alu_fn_e      fn,
  input  logic [W-1:0] opnd_a,
  input  logic [W-1:0] opnd_b,
  input  logic [W-1:0] cond_x,
  input  logic [W-1:0] cond_y,
  input  logic [W:0]   carry_vec,
  output logic [W-1:0] result
);

  logic [W-1:0] sum_bits;

  for (genvar i = 0; i < W; i++) begin : g_sum
    assign sum_bits[i] = cond_x[i] ^ cond_y[i] ^ carry_vec[i];
  end

  always_comb begin
    unique case (fn)
      FN_CLEAR:  result = '0;
      FN_NA_B,
      FN_A_NB,
      FN_ADD:    result = sum_bits;
      FN_XOR:    result = opnd_a ^ opnd_b;
      FN_OR:     result = opnd_a | opnd_b;
      FN_AND:    result = opnd_a & opnd_b;
      FN_PRESET: result = '1;
      default:   result = '0;
    endcase
  end

  // R6: an AND result never has a bit set that an OR result would clear
  always_comb begin
    if (fn == FN_AND) begin
      and_subset_chk: assert ((result & ~(opnd_a | opnd_b)) == '0);
    end
  end

endmodule

// File: rtl/lkalu_core.sv
module lkalu_core
  import lkalu_pkg::*;
#(
  parameter int W = 16
) (
  input  logic [W-1:0] opnd_a,
  input  logic [W-1:0] opnd_b,
  input  logic [2:0]   func_sel,
  input  logic         carry_in,
  output logic [W-1:0] result,
  output logic         zero_flag,
  output logic         ovf_flag,
  output logic         carry_out,
  output logic         grp_prop_n,
  output logic         grp_gen_n
);

  alu_fn_e      fn;
  logic [W-1:0] cond_x;
  logic [W-1:0] cond_y;
  logic [W:0]   carry_vec;
  logic         grp_gen;
  logic         grp_prop;
  logic         arith;

  assign fn    = alu_fn_e'(func_sel);
  assign arith = fn_is_arith(fn);

  lkalu_opnd_cond #(.W(W)) u_cond (
    .opnd_a (opnd_a),
    .opnd_b (opnd_b),
    .fn     (fn),
    .cond_x (cond_x),
    .cond_y (cond_y)
  );

  lkalu_prefix #(.W(W)) u_prefix (
    .cond_x    (cond_x),
    .cond_y    (cond_y),
    .carry_in  (carry_in),
    .carry_vec (carry_vec),
    .grp_gen   (grp_gen),
    .grp_prop  (grp_prop)
  );

  lkalu_result_mux #(.W(W)) u_mux (
    .fn        (fn),
    .opnd_a    (opnd_a),
    .opnd_b    (opnd_b),
    .cond_x    (cond_x),
    .cond_y    (cond_y),
    .carry_vec (carry_vec),
    .result    (result)
  );

  always_comb begin
    zero_flag = ~|result;
    if (arith) begin
      carry_out  = carry_vec[W];
      ovf_flag   = carry_vec[W-1] ^ carry_vec[W];
      grp_gen_n  = ~grp_gen;
      grp_prop_n = ~grp_prop;
    end else begin
      carry_out  = 1'b0;
      ovf_flag   = 1'b0;
      grp_gen_n  = 1'b1;
      grp_prop_n = 1'b1;
    end
  end

  always_comb begin
    // R1
    clear_zero_chk: assert (fn != FN_CLEAR || zero_flag);
    // R2
    preset_ones_chk: assert (fn != FN_PRESET || (&result));
    // R9
    gen_carry_chk: assert (!arith || grp_gen_n || carry_out);
    // R10
    quiet_flags_chk: assert (arith || (!carry_out && !ovf_flag && grp_gen_n && grp_prop_n));
    // R8
    if (arith && (cond_x[W-1] != cond_y[W-1])) begin
      mixed_sign_ovf_chk: assert (!ovf_flag);
    end
  end

endmodule

// File: tb/tb_lkalu_core.sv
module tb_lkalu_core;

  localparam int CLK_PERIOD = 10;
  localparam int WB = 16;
  localparam int WS = 4;

  logic clk;
  logic rst_n;

  logic [WB-1:0] a_b, b_b, r_b;
  logic [2:0]    s_b;
  logic          ci_b, z_b, v_b, co_b, pn_b, gn_b;

  logic [WS-1:0] a_s, b_s, r_s;
  logic [2:0]    s_s;
  logic          ci_s, z_s, v_s, co_s, pn_s, gn_s;

  int n_cmp = 0;
  int n_bad = 0;
  bit done  = 0;

  lkalu_core #(.W(WB)) dut (
    .opnd_a(a_b), .opnd_b(b_b), .func_sel(s_b), .carry_in(ci_b),
    .result(r_b), .zero_flag(z_b), .ovf_flag(v_b), .carry_out(co_b),
    .grp_prop_n(pn_b), .grp_gen_n(gn_b)
  );

  lkalu_core #(.W(WS)) dut_small (
    .opnd_a(a_s), .opnd_b(b_s), .func_sel(s_s), .carry_in(ci_s),
    .result(r_s), .zero_flag(z_s), .ovf_flag(v_s), .carry_out(co_s),
    .grp_prop_n(pn_s), .grp_gen_n(gn_s)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic cmp(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // Compare all outputs of one vector against the arithmetic model
  task automatic judge(input int w, input logic [31:0] a, input logic [31:0] b,
                       input logic [2:0] sel, input logic ci,
                       input logic [31:0] r, input logic z, input logic v,
                       input logic co, input logic pn, input logic gn);
    logic [31:0] mask, x, y, sum, exp_r;
    logic exp_co, exp_v, exp_gn, exp_pn, ar;
    string rq;
    mask = (32'd1 << w) - 1;
    x = (sel == 3'b001) ? (~a & mask) : a;
    y = (sel == 3'b010) ? (~b & mask) : b;
    sum = x + y + {31'd0, ci};
    ar = (sel == 3'b001) || (sel == 3'b010) || (sel == 3'b011);
    case (sel)
      3'b000: begin exp_r = 0;            rq = "R1"; end
      3'b001: begin exp_r = sum & mask;   rq = "R3"; end
      3'b010: begin exp_r = sum & mask;   rq = "R4"; end
      3'b011: begin exp_r = sum & mask;   rq = "R5"; end
      3'b100: begin exp_r = a ^ b;        rq = "R6"; end
      3'b101: begin exp_r = a | b;        rq = "R6"; end
      3'b110: begin exp_r = a & b;        rq = "R6"; end
      default: begin exp_r = mask;        rq = "R2"; end
    endcase
    if (ar) begin
      exp_co = sum[w];
      exp_v  = (x[w-1] == y[w-1]) && (sum[w-1] != x[w-1]);
      exp_gn = !(((x + y) >> w) & 32'd1);
      exp_pn = !((x | y) == mask);
      cmp(rq, "result", r, exp_r);
      cmp(rq, "carry_out", {31'd0, co}, {31'd0, exp_co});
      cmp("R8", "ovf_flag", {31'd0, v}, {31'd0, exp_v});
      cmp("R9", "grp_gen_n", {31'd0, gn}, {31'd0, exp_gn});
      cmp("R9", "grp_prop_n", {31'd0, pn}, {31'd0, exp_pn});
    end else begin
      cmp(rq, "result", r, exp_r);
      cmp("R10", "quiet flags", {28'd0, co, v, gn, pn}, 32'h3);
    end
    cmp("R7", "zero_flag", {31'd0, z}, {31'd0, (exp_r == 0)});
  endtask

  task automatic run_big(input logic [15:0] a, input logic [15:0] b,
                         input logic [2:0] sel, input logic ci);
    @(negedge clk);
    a_b = a; b_b = b; s_b = sel; ci_b = ci;
    #(CLK_PERIOD/4);
    judge(WB, {16'd0, a}, {16'd0, b}, sel, ci, {16'd0, r_b}, z_b, v_b, co_b, pn_b, gn_b);
  endtask

  initial begin : watchdog
    #(CLK_PERIOD * 150000);
    if (!done) begin
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog: actual running expected finished");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin : stim
    logic [31:0] seed;
    rst_n = 1'b0;
    a_b = '0; b_b = '0; s_b = 3'b000; ci_b = 1'b0;
    a_s = '0; b_s = '0; s_s = 3'b000; ci_s = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;

    // Idle state: clear with zero operands (R1, R7)
    #(CLK_PERIOD/4);
    cmp("R1", "idle result", {16'd0, r_b}, 32'd0);
    cmp("R7", "idle zero_flag", {31'd0, z_b}, 32'd1);

    // Exhaustive sweep of the narrow instance
    for (int sel = 0; sel < 8; sel++) begin
      for (int ci = 0; ci < 2; ci++) begin
        for (int a = 0; a < 16; a++) begin
          for (int b = 0; b < 16; b++) begin
            @(negedge clk);
            a_s = a[3:0]; b_s = b[3:0]; s_s = sel[2:0]; ci_s = ci[0];
            #(CLK_PERIOD/4);
            judge(WS, a, b, sel[2:0], ci[0], {28'd0, r_s}, z_s, v_s, co_s, pn_s, gn_s);
          end
        end
      end
    end

    // R11: subtraction forms with carry_in set
    run_big(16'd5, 16'd3, 3'b001, 1'b1);
    cmp("R11", "B-A", {16'd0, r_b}, 32'h0000FFFE);
    run_big(16'd5, 16'd3, 3'b010, 1'b1);
    cmp("R11", "A-B", {16'd0, r_b}, 32'h00000002);
    run_big(16'h8000, 16'h0001, 3'b010, 1'b1);
    cmp("R11", "A-B ovf result", {16'd0, r_b}, 32'h00007FFF);
    cmp("R8", "A-B ovf flag", {31'd0, v_b}, 32'd1);

    // Wide corner cases
    run_big(16'hFFFF, 16'h0001, 3'b011, 1'b0);
    run_big(16'hFFFF, 16'h0000, 3'b011, 1'b1);
    run_big(16'h7FFF, 16'h7FFF, 3'b011, 1'b1);
    run_big(16'h8000, 16'h8000, 3'b011, 1'b0);
    run_big(16'hAAAA, 16'h5555, 3'b100, 1'b1);
    run_big(16'hF0F0, 16'h0FF0, 3'b110, 1'b1);
    run_big(16'h1234, 16'h5678, 3'b111, 1'b1);
    run_big(16'h1234, 16'h5678, 3'b000, 1'b1);

    // Pseudo-random wide operands
    seed = 32'h1ACE_B00C;
    for (int k = 0; k < 4000; k++) begin
      seed = seed * 32'd1664525 + 32'd1013904223;
      run_big(seed[31:16], seed[15:0] ^ seed[23:8], k[2:0], k[3]);
    end

    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule